// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Core

This block is the digital core of a serial EEPROM slave. A host drives a select line, a serial clock and a serial data input. The block shifts in a start bit, a two-bit command code and a word address, and then shifts in a data word for the store commands. It answers read commands on a serial output that has its own drive enable, so the pad can be released to high impedance. A word-size input chooses between a 16-bit and an 8-bit view of the same storage.

The serial lines pass through two-flop synchronizers into a faster system clock, and the serial clock is edge-detected in that domain. The storage is a register array that resets to all ones. A write-enable latch guards every command that changes the array. Each accepted store or erase starts a self-timed busy period whose length is counted in system clocks. While that period runs, the host can toggle the select line and then read the ready/busy flag on the output.

Top module: `eep3w_core`

## Requirements
- R1: After reset, stores are disabled, the output drive enable is low and every stored bit reads as 1.
- R2: A frame begins on the first serial-clock rising edge, with select high, that samples data 1; data-0 edges before it are ignored. Two command bits follow, then the address MSB first: 8 bits in 16-bit mode (word16_i=1), or 9 bits in 8-bit mode (word16_i=0).
- R3: Command code 10 reads, 01 stores a word and 11 erases one word. Code 00 uses the top two address bits as a sub-code: 11 enables stores, 00 disables them, 10 erases the whole array and 01 fills the whole array with the data word. The remaining address bits are don't-care but are still clocked.
- R4: The single-word store, single-word erase, fill and full-erase commands change nothing while stores are disabled. Reads work in either state.
- R5: After the last address bit of a read, the output drives one 0 bit. The word then follows MSB first, with each bit presented after a serial-clock rising edge.
- R6: While select stays high, the next word follows the last bit at once with no extra 0 bit. The address wraps from the top of the array to 0.
- R7: A store writes the shifted-in word. In 8-bit mode, byte address b maps to word b>>1, where an even b selects the low byte and an odd b the high byte.
- R8: Erase sets the addressed word or byte to all ones. Full erase sets the whole array to ones, and fill writes the data word to every word (in 8-bit mode, to both bytes of every word).
- R9: Programming begins once the last bit is received and lasts PROG_CYCLES system clocks. If select goes low and then high during that time, the output drives 0 while busy and 1 once the period has ended.
- R10: If select rises after programming has ended, no status is driven.
- R11: Start bits are ignored while programming is in progress.
- R12: The output drive enable is low whenever select is low, and whenever the block is driving neither read data nor status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csel_i | input | 1 | Device select, high active |
| sclk_i | input | 1 | Serial clock |
| sdin_i | input | 1 | Serial data in |
| word16_i | input | 1 | 1 selects the 16-bit word view, 0 the 8-bit view |
| sdout_o | output | 1 | Serial data out (read data or ready/busy flag) |
| sdout_en_o | output | 1 | Drive enable for the serial output |

## Verification
A cycle of the status flag can fall on the same select-high period as a new start bit. The bench provokes this by raising select during programming, reading the busy 0, and then at once clocking a complete store frame with the flag still shown. It judges the result by letting the period expire, confirming that no status comes back on a later select rise, and reading the target word to show that it is still erased. The same flow also checks that the flag turns to 1 in place when programming ends under a held select.

// File: rtl/eep3w_pkg.sv
// Shared types for the three-wire EEPROM core: frame states, commands
// and the command decoder. Assumes a 2-bit command code and a 2-bit sub-code.
package eep3w_pkg;

    typedef enum logic [2:0] {
        ST_IDLE, ST_OPC, ST_ADDR, ST_DATA, ST_READ, ST_HOLD
    } eep_st_t;

    typedef enum logic [2:0] {
        CMD_READ, CMD_WRITE, CMD_ERASE, CMD_WEN, CMD_WDIS, CMD_ERALL, CMD_FILL
    } eep_cmd_t;

    // Map command code and top address bits to a command.
    function automatic eep_cmd_t eep_decode(logic [1:0] code, logic [1:0] sub);
        eep_cmd_t c;
        case (code)
            2'b10:   c = CMD_READ;
            2'b01:   c = CMD_WRITE;
            2'b11:   c = CMD_ERASE;
            default: begin
                case (sub)
                    2'b11:   c = CMD_WEN;
                    2'b10:   c = CMD_ERALL;
                    2'b01:   c = CMD_FILL;
                    default: c = CMD_WDIS;
                endcase
            end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/eep3w_sync.sv
// Two-flop synchronizer for a vector of independent asynchronous inputs.
// Assumes each bit is a slow level, so no bit-to-bit coherence is needed.
module eep3w_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;

    // Two-stage capture into the system clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q_o    <= '0;
        end else begin
            meta_q <= a_i;
            q_o    <= meta_q;
        end
    end
endmodule

// File: rtl/eep3w_array.sv
// Storage array of 2**AW words with byte masks and a bulk write. It resets
// to all ones and has a combinational read port. Assumes DW is even.
module eep3w_array #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic          bulk_i,
    input  logic [1:0]    mask_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);
    localparam int DEPTH = 1 << AW;
    localparam int HB    = DW / 2;

    logic [DW-1:0] mem_q [DEPTH];

    // Reset to erased; write one word or all words under the byte mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
        end else if (we_i) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (bulk_i || (AW'(i) == waddr_i)) begin
                    if (mask_i[0]) mem_q[i][HB-1:0]  <= wdata_i[HB-1:0];
                    if (mask_i[1]) mem_q[i][DW-1:HB] <= wdata_i[DW-1:HB];
                end
            end
        end
    end

    assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/eep3w_timer.sv
// Self-timed programming period: busy for CYC clocks after a start pulse.
// Assumes CYC >= 1 and that no start arrives while busy.
module eep3w_timer #(
    parameter int CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);
    localparam int CW = $clog2(CYC + 1);

    logic [CW-1:0] left_q;

    // Load on start, count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                left_q <= '0;
        else if (start_i)          left_q <= CW'(CYC);
        else if (left_q != '0)     left_q <= left_q - 1'b1;
    end

    assign busy_o = (left_q != '0);
endmodule

// File: rtl/eep3w_core.sv
// Three-wire serial EEPROM device core. It synchronizes select, serial clock,
// data and word size, and decodes frames on serial-clock rising edges. It
// drives read data or the ready/busy flag with a separate enable. Assumes
// the serial clock phases each last several system clocks and that the word
// size changes only while select is low.
module eep3w_core #(
    parameter int AW_W        = 8,
    parameter int WORD_W      = 16,
    parameter int PROG_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic csel_i,
    input  logic sclk_i,
    input  logic sdin_i,
    input  logic word16_i,
    output logic sdout_o,
    output logic sdout_en_o
);
    import eep3w_pkg::*;

    localparam int AW_N   = AW_W + 1;
    localparam int BYTE_W = WORD_W / 2;
    localparam int CNTW   = $clog2(((AW_N > WORD_W) ? AW_N : WORD_W) + 1);

    logic cs_s, sk_s, di_s, wide_s, sk_d, cs_d, sk_rise, cs_rise;
    eep_st_t  st_q;
    eep_cmd_t cmd_q, cmd_nx, l_cmd;
    logic [CNTW-1:0]   cnt_q, aw_len, dw_len;
    logic [1:0]        op_q, sub_nx, l_mask;
    logic [AW_N-1:0]   addr_q, addr_nx, ptr_q, l_addr;
    logic [WORD_W-1:0] data_q, data_nx, rd_sh_q, rd_load, rd_word, l_data;
    logic [AW_W-1:0]   rd_idx, l_idx;
    logic reload_q, do_q, wen_q, stat_q, busy, launch, l_bulk;
    logic pg_q, pg_bulk_q;
    logic [1:0]        pg_mask_q;
    logic [AW_W-1:0]   pg_idx_q;
    logic [WORD_W-1:0] pg_data_q;

    eep3w_sync #(.W(4)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .a_i({csel_i, sclk_i, sdin_i, word16_i}),
        .q_o({cs_s, sk_s, di_s, wide_s})
    );

    // Delayed copies for edge detection of serial clock and select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sk_d <= 1'b0;
            cs_d <= 1'b0;
        end else begin
            sk_d <= sk_s;
            cs_d <= cs_s;
        end
    end

    assign sk_rise = sk_s & ~sk_d & cs_s;
    assign cs_rise = cs_s & ~cs_d;

    // Next shift values, field lengths, decode and the program launch.
    always_comb begin
        addr_nx = {addr_q[AW_N-2:0], di_s};
        data_nx = {data_q[WORD_W-2:0], di_s};
        sub_nx  = wide_s ? addr_nx[AW_W-1 -: 2] : addr_nx[AW_N-1 -: 2];
        cmd_nx  = eep_decode(op_q, sub_nx);
        aw_len  = wide_s ? CNTW'(AW_W) : CNTW'(AW_N);
        dw_len  = wide_s ? CNTW'(WORD_W) : CNTW'(BYTE_W);
        rd_idx  = wide_s ? ptr_q[AW_W-1:0] : ptr_q[AW_N-1:1];
        if (wide_s)        rd_load = rd_word;
        else if (ptr_q[0]) rd_load = {rd_word[WORD_W-1:BYTE_W], {BYTE_W{1'b0}}};
        else               rd_load = {rd_word[BYTE_W-1:0], {BYTE_W{1'b0}}};
        l_cmd  = (st_q == ST_ADDR) ? cmd_nx : cmd_q;
        l_addr = (st_q == ST_ADDR) ? addr_nx : addr_q;
        l_bulk = (l_cmd == CMD_ERALL) || (l_cmd == CMD_FILL);
        l_idx  = wide_s ? l_addr[AW_W-1:0] : l_addr[AW_N-1:1];
        if (wide_s || l_bulk) l_mask = 2'b11;
        else                  l_mask = l_addr[0] ? 2'b10 : 2'b01;
        if ((l_cmd == CMD_ERASE) || (l_cmd == CMD_ERALL)) l_data = '1;
        else if (wide_s) l_data = data_nx;
        else             l_data = {data_nx[BYTE_W-1:0], data_nx[BYTE_W-1:0]};
        launch = sk_rise && wen_q &&
                 (((st_q == ST_ADDR) && (cnt_q == aw_len - 1'b1) &&
                   ((cmd_nx == CMD_ERASE) || (cmd_nx == CMD_ERALL))) ||
                  ((st_q == ST_DATA) && (cnt_q == dw_len - 1'b1) &&
                   ((cmd_q == CMD_WRITE) || (cmd_q == CMD_FILL))));
    end

    // Register the program request for the array and the timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pg_q      <= 1'b0;
            pg_bulk_q <= 1'b0;
            pg_mask_q <= '0;
            pg_idx_q  <= '0;
            pg_data_q <= '0;
        end else begin
            pg_q <= launch;
            if (launch) begin
                pg_bulk_q <= l_bulk;
                pg_mask_q <= l_mask;
                pg_idx_q  <= l_idx;
                pg_data_q <= l_data;
            end
        end
    end

    // Frame state machine, enable latch, read shifter and status flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;  cmd_q <= CMD_READ;  cnt_q <= '0;  op_q <= '0;
            addr_q <= '0;  data_q <= '0;  ptr_q <= '0;  rd_sh_q <= '0;
            reload_q <= 1'b0;  do_q <= 1'b0;  wen_q <= 1'b0;  stat_q <= 1'b0;
        end else begin
            if (reload_q) begin
                rd_sh_q  <= rd_load;
                reload_q <= 1'b0;
            end
            if (cs_rise && busy) stat_q <= 1'b1;
            if (!cs_s) begin
                st_q     <= ST_IDLE;
                stat_q   <= 1'b0;
                reload_q <= 1'b0;
            end else if (sk_rise) begin
                case (st_q)
                    ST_IDLE: if (di_s && !busy) begin
                        st_q   <= ST_OPC;
                        cnt_q  <= '0;
                        stat_q <= 1'b0;
                    end
                    ST_OPC: begin
                        op_q <= {op_q[0], di_s};
                        if (cnt_q == CNTW'(1)) begin
                            st_q  <= ST_ADDR;
                            cnt_q <= '0;
                        end else cnt_q <= cnt_q + 1'b1;
                    end
                    ST_ADDR: begin
                        addr_q <= addr_nx;
                        if (cnt_q == aw_len - 1'b1) begin
                            cnt_q <= '0;
                            cmd_q <= cmd_nx;
                            case (cmd_nx)
                                CMD_READ: begin
                                    ptr_q    <= addr_nx;
                                    reload_q <= 1'b1;
                                    do_q     <= 1'b0;
                                    st_q     <= ST_READ;
                                end
                                CMD_WRITE, CMD_FILL: st_q <= ST_DATA;
                                CMD_WEN:  begin wen_q <= 1'b1; st_q <= ST_HOLD; end
                                CMD_WDIS: begin wen_q <= 1'b0; st_q <= ST_HOLD; end
                                default:  st_q <= ST_HOLD;
                            endcase
                        end else cnt_q <= cnt_q + 1'b1;
                    end
                    ST_DATA: begin
                        data_q <= data_nx;
                        if (cnt_q == dw_len - 1'b1) st_q <= ST_HOLD;
                        else cnt_q <= cnt_q + 1'b1;
                    end
                    ST_READ: begin
                        do_q    <= rd_sh_q[WORD_W-1];
                        rd_sh_q <= {rd_sh_q[WORD_W-2:0], 1'b0};
                        if (cnt_q == dw_len - 1'b1) begin
                            cnt_q    <= '0;
                            ptr_q    <= ptr_q + 1'b1;
                            reload_q <= 1'b1;
                        end else cnt_q <= cnt_q + 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    eep3w_array #(.AW(AW_W), .DW(WORD_W)) u_array (
        .clk(clk), .rst_n(rst_n), .we_i(pg_q), .bulk_i(pg_bulk_q),
        .mask_i(pg_mask_q), .waddr_i(pg_idx_q), .wdata_i(pg_data_q),
        .raddr_i(rd_idx), .rdata_o(rd_word)
    );

    eep3w_timer #(.CYC(PROG_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start_i(pg_q), .busy_o(busy)
    );

    assign sdout_en_o = cs_s && (stat_q || (st_q == ST_READ));
    assign sdout_o    = stat_q ? ~busy : do_q;
endmodule

// File: rtl/eep3w_chk.sv
// Assertion checker for eep3w_core, attached by bind. It observes the
// synchronized select, the frame state, the enable latch, the program pulse
// and the busy timer.
module eep3w_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_s,
    input logic       sdout_en,
    input logic       stat,
    input logic       busy,
    input logic       pg,
    input logic       wen,
    input logic [2:0] st
);
    localparam logic [2:0] IDLE = 3'd0;
    localparam logic [2:0] OPC  = 3'd1;
    localparam logic [2:0] READ = 3'd4;

    a_r12_drive_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        sdout_en |-> cs_s);
    a_r4_prog_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        pg |-> wen);
    a_r9_busy_after_launch: assert property (@(posedge clk) disable iff (!rst_n)
        pg |=> busy);
    a_r10_status_only_if_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat) |-> $past(busy));
    a_r11_no_start_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (st == IDLE && busy) |=> st != OPC);
    a_r5_data_only_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        (sdout_en && !stat) |-> st == READ);
endmodule

bind eep3w_core eep3w_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sdout_en(sdout_en_o),
    .stat(stat_q), .busy(busy), .pg(pg_q), .wen(wen_q), .st(st_q)
);

// File: tb/eep3w_core_tb.sv
// Scoreboard bench: driver tasks push expected output bits, a monitor pops
// and compares them against sampled bits.
module eep3w_core_tb;
    logic clk = 1'b0, rst_n = 1'b0, csel = 1'b0, sclk = 1'b0, sdin = 1'b0, word16 = 1'b1;
    logic sdout, sdout_en;
    int checks = 0, errors = 0;
    bit done = 0;

    typedef struct { logic v; string tag; } exp_t;
    exp_t exp_q[$];
    logic obs_q[$];
    logic [15:0] model [256];
    bit en_model = 0;

    always #10 clk = ~clk;

    eep3w_core u_dut (
        .clk(clk), .rst_n(rst_n), .csel_i(csel), .sclk_i(sclk), .sdin_i(sdin),
        .word16_i(word16), .sdout_o(sdout), .sdout_en_o(sdout_en)
    );

    task automatic check(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: pop expected and observed bits and compare.
    initial begin
        exp_t e;
        logic o;
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0 && obs_q.size() > 0) begin
                e = exp_q.pop_front();
                o = obs_q.pop_front();
                check(o === e.v, e.tag, {15'd0, o}, {15'd0, e.v});
            end
        end
    end

    task automatic clk_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_io(logic v, output logic s, output logic en);
        sdin = v;
        clk_n(8);
        s  = sdout;
        en = sdout_en;
        sclk = 1'b1;
        clk_n(8);
        sclk = 1'b0;
    endtask

    function automatic int aw();
        return word16 ? 8 : 9;
    endfunction

    function automatic int dw();
        return word16 ? 16 : 8;
    endfunction

    // One leading 0 bit (ignored, R2), start bit, command code, address.
    task automatic send(logic [1:0] op, int addr);
        logic s, e;
        csel = 1'b1;
        clk_n(4);
        bit_io(1'b0, s, e);
        bit_io(1'b1, s, e);
        bit_io(op[1], s, e);
        bit_io(op[0], s, e);
        for (int b = aw() - 1; b >= 0; b--) bit_io(addr[b], s, e);
    endtask

    task automatic send_data(logic [15:0] d);
        logic s, e;
        for (int b = dw() - 1; b >= 0; b--) bit_io(d[b], s, e);
    endtask

    task automatic stop();
        csel = 1'b0;
        sdin = 1'b0;
        clk_n(8);
    endtask

    function automatic logic [15:0] model_rd(int a);
        if (word16) return model[a % 256];
        if (a[0]) return {8'd0, model[(a % 512) >> 1][15:8]};
        return {8'd0, model[(a % 512) >> 1][7:0]};
    endfunction

    task automatic model_wr(int a, logic [15:0] d);
        if (!en_model) return;
        if (word16) model[a % 256] = d;
        else if (a[0]) model[(a % 512) >> 1][15:8] = d[7:0];
        else model[(a % 512) >> 1][7:0] = d[7:0];
    endtask

    task automatic do_write(int a, logic [15:0] d);
        send(2'b01, a);
        send_data(d);
        stop();
        model_wr(a, d);
    endtask

    task automatic do_read(int a, int nw, string tag);
        logic s, e;
        logic [15:0] w;
        exp_t x;
        send(2'b10, a);
        x.v = 1'b0; x.tag = {tag, " dummy bit"}; exp_q.push_back(x);
        for (int k = 0; k < nw; k++) begin
            w = model_rd(a + k);
            for (int b = dw() - 1; b >= 0; b--) begin
                x.v = w[b]; x.tag = {tag, " data bit"}; exp_q.push_back(x);
            end
        end
        for (int i = 0; i < 1 + nw * dw(); i++) begin
            bit_io(1'b0, s, e);
            obs_q.push_back(e ? s : 1'bx);
        end
        stop();
    endtask

    task automatic probe(logic exp_en, logic exp_v, string tag);
        csel = 1'b1;
        clk_n(8);
        check(sdout_en === exp_en, {tag, " drive enable"}, {15'd0, sdout_en}, {15'd0, exp_en});
        if (exp_en) check(sdout === exp_v, {tag, " status"}, {15'd0, sdout}, {15'd0, exp_v});
    endtask

    task automatic finish_run();
        if (done) return;
        done = 1;
        clk_n(4);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 256; i++) model[i] = 16'hFFFF;
        clk_n(5);
        rst_n = 1'b1;
        clk_n(5);
        check(sdout_en === 1'b0, "R1 reset drive enable", {15'd0, sdout_en}, 16'd0);
        probe(1'b0, 1'b0, "R12 idle select high");
        stop();
        // R4: store while disabled is ignored; R1 erased contents.
        do_write(5, 16'hA5C3);
        probe(1'b0, 1'b0, "R4 no programming started");
        stop();
        do_read(5, 1, "R1 R4 disabled store");
        // R3: enable sub-code 11, then store and watch status (R9).
        send(2'b00, 8'hC0); stop(); en_model = 1;
        do_write(5, 16'hA5C3);
        probe(1'b1, 1'b0, "R9 busy");
        clk_n(1100);
        check(sdout === 1'b1, "R9 ready", {15'd0, sdout}, 16'd1);
        stop();
        do_read(5, 2, "R5 R6 sequential read");
        // R11: store while busy ignored; R10 no status after end.
        do_write(7, 16'h1234);
        probe(1'b1, 1'b0, "R11 busy before frame");
        send(2'b01, 6); send_data(16'hBEEF); stop();
        clk_n(1100);
        probe(1'b0, 1'b0, "R10 late select");
        stop();
        do_read(6, 1, "R11 ignored store");
        do_read(7, 1, "R7 store");
        // R6: wrap from top address to 0.
        do_write(255, 16'h0F0F); clk_n(1100);
        do_read(255, 2, "R6 wrap");
        // R8: single erase.
        send(2'b11, 5); stop(); model[5] = 16'hFFFF; clk_n(1100);
        do_read(5, 1, "R8 erase");
        // R7: 8-bit view, odd byte maps to high byte.
        word16 = 1'b0; clk_n(8);
        do_write(9, 16'h003C); clk_n(1100);
        do_read(9, 2, "R7 byte read");
        word16 = 1'b1; clk_n(8);
        do_read(4, 1, "R7 byte map");
        // R8: fill in 8-bit view replicates the byte.
        word16 = 1'b0; clk_n(8);
        send(2'b00, 9'h080); send_data(16'h005A); stop(); clk_n(1100);
        for (int i = 0; i < 256; i++) model[i] = 16'h5A5A;
        word16 = 1'b1; clk_n(8);
        do_read(3, 1, "R8 fill");
        // R8: full erase.
        send(2'b00, 8'h80); stop(); clk_n(1100);
        for (int i = 0; i < 256; i++) model[i] = 16'hFFFF;
        do_read(200, 1, "R8 full erase");
        // R4: disable sub-code 00, store ignored.
        send(2'b00, 8'h00); stop(); en_model = 0;
        do_write(2, 16'h7777); clk_n(1100);
        do_read(2, 1, "R3 R4 disabled again");
        clk_n(4);
        finish_run();
    end
endmodule